// File: doc/BRIEF.md
# Reloadable Down-Counting Timer Channel

This block is a single timer channel that counts down by one on each cycle where a shared tick strobe arrives and the channel is enabled. Software-style write strobes set the count directly, set a stored reload value, or write a control word. The control word enables counting, selects automatic restart, enables the interrupt and can order an immediate copy of the reload value into the count.

The channel expires when a tick arrives while the count is already zero. The count then wraps below zero. On expiry, the channel reloads itself when restart is selected, and otherwise it stops and drops its enable. With the interrupt enabled, expiry sets a sticky pending flag and produces a one-cycle interrupt pulse. The pending flag is cleared only by writing a one to its position in the control word. All three registers are visible at the outputs at all times, so the surrounding bus logic can read them without extra timing.

Top module: `dtimer_channel`

## Requirements
- R1: After reset the count, the reload value, the control read value and the interrupt output are all zero.
- R2: The count drops by one at a clock edge only when the tick strobe is high, the enable bit (control bit 0) is set, and no count write or control write happens in that cycle. A tick with enable clear leaves the count unchanged.
- R3: A count of N expires on the (N+1)-th enabled tick, when the count is zero and a tick arrives. Without restart, the count then reads all ones.
- R4: On expiry with interrupt enable (control bit 3) set, pending (control bit 4) becomes 1 and the interrupt output is high for exactly the one cycle after that edge. Expiry with interrupt enable clear sets neither.
- R5: On expiry with auto-restart (control bit 1) set, the count takes the reload value and counting continues. With a reload value of zero and a tick every cycle, the channel expires on every tick.
- R6: On expiry without auto-restart, the enable bit clears and later ticks leave the count unchanged.
- R7: A control write with bit 4 = 1 clears pending. A control write with bit 4 = 0 keeps the current pending value.
- R8: A control write with the load bit (bit 2) set copies the reload value into the count. Bit 2 always reads as 0.
- R9: A count write puts the written data into the count at the next edge and takes priority over a tick in the same cycle. Counting then continues from that value if enable is set.
- R10: A reload write changes only the stored reload value. It does not change the count.
- R11: The control read value holds only enable, auto-restart, interrupt enable and pending at bits 0, 1, 3 and 4. Bits 5, 6 and all higher bits are not stored and read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Shared count strobe |
| wr_cnt | input | 1 | Write strobe for the count |
| wr_rld | input | 1 | Write strobe for the reload value |
| wr_ctl | input | 1 | Write strobe for the control word |
| wdata | input | W (32) | Write data for all three registers |
| cnt_q | output | W (32) | Current count |
| rld_q | output | W (32) | Stored reload value |
| ctl_q | output | W (32) | Control and status read value |
| irq | output | 1 | One-cycle interrupt pulse on expiry |

## Verification
Every register sits directly on an output, so a wrong count, a stuck enable or a lost pending flag shows at the ports on the cycle right after the edge that caused it. A wrong expiry point is the hardest fault to see. It appears only when the count is driven through zero, as a misplaced interrupt pulse, a count that reads 0 where all ones or the reload value is expected, or an enable bit that should have cleared. The stimulus therefore crosses zero with and without restart, with and without interrupt enable, and with a reload of zero, where expiries come back to back.

// File: rtl/dtimer_pkg.sv
`timescale 1ns/1ps
package dtimer_pkg;
  // Control word bit positions
  localparam int unsigned CB_EN = 0;
  localparam int unsigned CB_RS = 1;
  localparam int unsigned CB_LD = 2;
  localparam int unsigned CB_IE = 3;
  localparam int unsigned CB_PD = 4;
  localparam int unsigned CB_TOP = CB_PD;

  typedef struct packed {
    logic pend;
    logic ie;
    logic rs;
    logic en;
  } ctl_t;
endpackage

// File: rtl/dtimer_ctl.sv
`timescale 1ns/1ps
module dtimer_ctl
  import dtimer_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_ctl,
  input  logic [CB_TOP:0] wbits,
  input  logic            expire,
  output logic            load_cmd,
  output ctl_t            ctl_q
);
  logic armed_q;

  assign load_cmd = wr_ctl & wbits[CB_LD];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (wr_ctl) begin
        ctl_q.en   <= wbits[CB_EN];
        ctl_q.rs   <= wbits[CB_RS];
        ctl_q.ie   <= wbits[CB_IE];
        ctl_q.pend <= wbits[CB_PD] ? 1'b0 : ctl_q.pend;
      end else if (expire) begin
        if (ctl_q.ie) ctl_q.pend <= 1'b1;
        if (!ctl_q.rs) ctl_q.en <= 1'b0;
      end
    end
  end

  assert_pend_clear_R7: assert property (@(posedge clk) disable iff (rst || !armed_q)
    $past(wr_ctl && wbits[CB_PD]) |-> !ctl_q.pend);

  assert_pend_keep_R7: assert property (@(posedge clk) disable iff (rst || !armed_q)
    $past(wr_ctl && !wbits[CB_PD]) |-> ctl_q.pend == $past(ctl_q.pend));

  assert_stop_R6: assert property (@(posedge clk) disable iff (rst || !armed_q)
    $past(expire && !ctl_q.rs) |-> !ctl_q.en);

  assert_pend_set_R4: assert property (@(posedge clk) disable iff (rst || !armed_q)
    $past(expire && ctl_q.ie) |-> ctl_q.pend);
endmodule

// File: rtl/dtimer_count.sv
`timescale 1ns/1ps
module dtimer_count #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         en,
  input  logic         rs,
  input  logic         wr_cnt,
  input  logic         wr_rld,
  input  logic         wr_ctl,
  input  logic         load_cmd,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] rld_q,
  output logic         expire
);
  localparam logic [W-1:0] ONE = W'(1);

  logic step;
  logic armed_q;

  // Register writes in the same cycle win over a tick.
  assign step   = tick & en & ~wr_cnt & ~wr_ctl;
  assign expire = step & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (wr_cnt)             cnt_q <= wdata;
      else if (load_cmd)      cnt_q <= rld_q;
      else if (expire && rs)  cnt_q <= rld_q;
      else if (step)          cnt_q <= cnt_q - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rld_q <= '0;
    else if (wr_rld) rld_q <= wdata;
  end

  assert_cnt_write_R9: assert property (@(posedge clk) disable iff (rst || !armed_q)
    $past(wr_cnt) |-> cnt_q == $past(wdata));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst || !armed_q)
    $past(!wr_cnt && !load_cmd && !(tick && en)) |-> cnt_q == $past(cnt_q));

  assert_rld_hold_R10: assert property (@(posedge clk) disable iff (rst || !armed_q)
    $past(!wr_rld) |-> rld_q == $past(rld_q));

  assert_restart_R5: assert property (@(posedge clk) disable iff (rst || !armed_q)
    $past(expire && rs) |-> cnt_q == $past(rld_q));

  assert_load_R8: assert property (@(posedge clk) disable iff (rst || !armed_q)
    $past(load_cmd && !wr_cnt) |-> cnt_q == $past(rld_q));
endmodule

// File: rtl/dtimer_irq.sv
`timescale 1ns/1ps
module dtimer_irq (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic ie,
  output logic irq_q
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      irq_q   <= expire & ie;
    end
  end

  assert_irq_cause_R4: assert property (@(posedge clk) disable iff (rst || !armed_q)
    irq_q |-> $past(expire));
endmodule

// File: rtl/dtimer_channel.sv
`timescale 1ns/1ps
module dtimer_channel
  import dtimer_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wr_cnt,
  input  logic         wr_rld,
  input  logic         wr_ctl,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] rld_q,
  output logic [W-1:0] ctl_q,
  output logic         irq
);
  ctl_t ctl;
  logic load_cmd;
  logic expire;

  dtimer_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .wr_ctl   (wr_ctl),
    .wbits    (wdata[CB_TOP:0]),
    .expire   (expire),
    .load_cmd (load_cmd),
    .ctl_q    (ctl)
  );

  dtimer_count #(.W(W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .en       (ctl.en),
    .rs       (ctl.rs),
    .wr_cnt   (wr_cnt),
    .wr_rld   (wr_rld),
    .wr_ctl   (wr_ctl),
    .load_cmd (load_cmd),
    .wdata    (wdata),
    .cnt_q    (cnt_q),
    .rld_q    (rld_q),
    .expire   (expire)
  );

  dtimer_irq u_irq (
    .clk    (clk),
    .rst    (rst),
    .expire (expire),
    .ie     (ctl.ie),
    .irq_q  (irq)
  );

  // Read view: only the four stored fields, the rest reads zero (R11).
  always_comb begin
    ctl_q        = '0;
    ctl_q[CB_EN] = ctl.en;
    ctl_q[CB_RS] = ctl.rs;
    ctl_q[CB_IE] = ctl.ie;
    ctl_q[CB_PD] = ctl.pend;
  end

  assert_irq_pend_R4: assert property (@(posedge clk) disable iff (rst)
    irq |-> ctl_q[CB_PD]);
endmodule

// File: tb/tb_dtimer_channel.sv
`timescale 1ns/1ps
module tb_dtimer_channel;
  localparam int W = 32;
  localparam logic [31:0] EN = 32'h01, RS = 32'h02, LD = 32'h04, IE = 32'h08, PD = 32'h10;
  localparam logic [31:0] F = 32'hFFFF_FFFF;

  typedef struct packed {
    logic [31:0] cnt;
    logic [31:0] rld;
    logic [31:0] ctl;
    logic        irq;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, wr_cnt = 1'b0, wr_rld = 1'b0, wr_ctl = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] cnt_q, rld_q, ctl_q;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  exp_t  exp_q[$];
  string req_q[$];

  always #2.5 clk = ~clk;

  dtimer_channel #(.W(W)) dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_cnt(wr_cnt), .wr_rld(wr_rld),
    .wr_ctl(wr_ctl), .wdata(wdata), .cnt_q(cnt_q), .rld_q(rld_q),
    .ctl_q(ctl_q), .irq(irq)
  );

  // Monitor: compares outputs against queued expectations.
  always @(negedge clk) begin
    if (!rst && exp_q.size() > 0) begin
      exp_t e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      n_chk++;
      if (cnt_q !== e.cnt || rld_q !== e.rld || ctl_q !== e.ctl || irq !== e.irq) begin
        n_fail++;
        $display("FAIL %s: cnt=%h rld=%h ctl=%h irq=%b expected cnt=%h rld=%h ctl=%h irq=%b",
                 r, cnt_q, rld_q, ctl_q, irq, e.cnt, e.rld, e.ctl, e.irq);
      end
    end
  end

  task automatic expect_now(input string r, input logic [31:0] c, input logic [31:0] l,
                            input logic [31:0] k, input logic i);
    exp_q.push_back('{cnt: c, rld: l, ctl: k, irq: i});
    req_q.push_back(r);
  endtask

  // Driver: one cycle of stimulus, then the state expected after that edge.
  task automatic cyc(input logic t, input logic wc, input logic wr, input logic wl,
                     input logic [31:0] d, input string r, input logic [31:0] c,
                     input logic [31:0] l, input logic [31:0] k, input logic i);
    @(negedge clk);
    tick = t; wr_cnt = wc; wr_rld = wr; wr_ctl = wl; wdata = d;
    @(posedge clk);
    #1;
    tick = 1'b0; wr_cnt = 1'b0; wr_rld = 1'b0; wr_ctl = 1'b0; wdata = '0;
    expect_now(r, c, l, k, i);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    expect_now("R1", 0, 0, 0, 0);
    // R9 count write, R2 tick ignored while disabled
    cyc(0,1,0,0, 3,        "R9", 3, 0, 0, 0);
    cyc(1,0,0,0, 0,        "R2", 3, 0, 0, 0);
    cyc(0,0,0,1, EN|IE,    "R11", 3, 0, EN|IE, 0);
    cyc(1,0,0,0, 0,        "R2", 2, 0, EN|IE, 0);
    cyc(1,0,0,0, 0,        "R2", 1, 0, EN|IE, 0);
    cyc(1,0,0,0, 0,        "R2", 0, 0, EN|IE, 0);
    // R3 fourth tick from 3 expires, wraps, R6 enable drops
    cyc(1,0,0,0, 0,        "R3", F, 0, IE|PD, 1);
    cyc(0,0,0,0, 0,        "R4", F, 0, IE|PD, 0);
    cyc(1,0,0,0, 0,        "R6", F, 0, IE|PD, 0);
    cyc(0,0,1,0, 5,        "R10", F, 5, IE|PD, 0);
    // R8 load from reload, bit 2 reads 0, pending kept (bit4 written 0)
    cyc(0,0,0,1, EN|RS|LD|IE, "R8", 5, 5, EN|RS|IE|PD, 0);
    cyc(1,0,0,0, 0,        "R2", 4, 5, EN|RS|IE|PD, 0);
    cyc(0,0,0,0, 0,        "R2", 4, 5, EN|RS|IE|PD, 0);
    cyc(0,0,1,0, 2,        "R10", 4, 2, EN|RS|IE|PD, 0);
    cyc(1,0,0,0, 0,        "R2", 3, 2, EN|RS|IE|PD, 0);
    cyc(1,0,0,0, 0,        "R2", 2, 2, EN|RS|IE|PD, 0);
    cyc(1,0,0,0, 0,        "R2", 1, 2, EN|RS|IE|PD, 0);
    cyc(1,0,0,0, 0,        "R2", 0, 2, EN|RS|IE|PD, 0);
    cyc(1,0,0,0, 0,        "R5", 2, 2, EN|RS|IE|PD, 1);
    cyc(0,0,0,1, EN|RS|IE|PD, "R7", 2, 2, EN|RS|IE, 0);
    cyc(1,0,0,0, 0,        "R5", 1, 2, EN|RS|IE, 0);
    cyc(1,0,0,0, 0,        "R5", 0, 2, EN|RS|IE, 0);
    cyc(1,0,0,0, 0,        "R4", 2, 2, EN|RS|IE|PD, 1);
    cyc(0,0,0,1, EN|RS|IE, "R7", 2, 2, EN|RS|IE|PD, 0);
    cyc(0,0,0,1, EN|RS|PD, "R7", 2, 2, EN|RS, 0);
    cyc(1,0,0,0, 0,        "R5", 1, 2, EN|RS, 0);
    cyc(1,0,0,0, 0,        "R5", 0, 2, EN|RS, 0);
    cyc(1,0,0,0, 0,        "R4", 2, 2, EN|RS, 0);
    // R9 write wins over a tick in the same cycle
    cyc(1,1,0,0, 7,        "R9", 7, 2, EN|RS, 0);
    cyc(1,0,0,0, 0,        "R9", 6, 2, EN|RS, 0);
    cyc(0,0,0,1, 32'h61,   "R11", 6, 2, EN, 0);
    cyc(1,0,0,0, 0,        "R2", 5, 2, EN, 0);
    cyc(0,0,1,0, 0,        "R10", 5, 0, EN, 0);
    cyc(0,0,0,1, EN|RS|LD|IE, "R8", 0, 0, EN|RS|IE, 0);
    // R5 reload of zero: expiry on every tick
    cyc(1,0,0,0, 0,        "R5", 0, 0, EN|RS|IE|PD, 1);
    cyc(1,0,0,0, 0,        "R5", 0, 0, EN|RS|IE|PD, 1);
    cyc(0,0,0,1, PD,       "R7", 0, 0, 0, 0);
    cyc(1,0,0,0, 0,        "R2", 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    finished = 1'b1;
    finish_run();
  end
endmodule